// File: doc/BRIEF.md
# Register-Mapped Pulse-Width Modulator with Prescaler

This block drives one pulse-width modulated output. Software configures it through a small 32-bit word register port. A control word enables the generator, picks which of two clock-enable streams advances it, sets a 12-bit divide ratio, and says whether counting goes on while the chip is in its debug, wait or doze low-power states. A duty word and a period word set the waveform. The source ticks are divided by the prescaler, and each divided tick advances a 16-bit period counter. The output is high while the count is below the duty word.

The whole block runs on a single clock. The two clock sources reach it as single-cycle enable strobes from the clock tree, so no clock is ever muxed inside the block. New duty and period values are held in shadow registers and take effect only when a period completes. Because of this, software can retune the waveform at any time without producing a runt pulse.

Top module: `pwm_regmap_gen`

## Requirements
- R1: After reset every register reads zero and `pwm_out` is low.
- R2: The control word is at byte offset 0x00 and keeps only these bits: 0 (run), 15:4 (prescaler), 17:16 (source), 22 (run during debug), 23 (run during wait), 24 (run during doze). All other bits read zero. The duty word is at 0x0C and the period word is at 0x10; each keeps its low 16 bits and reads zero above them. Reads at any other offset return zero, and writes there change nothing.
- R3: While the run bit is clear, `pwm_out` is low and the prescaler and period counter are held at zero. Setting the run bit starts the first period at count zero, so the output is high on the very next cycle when the duty word is nonzero.
- R4: The prescaler field holds the divide ratio minus one. With field value P, the period counter advances once every P+1 selected source ticks; 0 divides by 1 and 0xFFF divides by 4096.
- R5: A period lasts the period word plus two counter steps. Period words 0xFFFE and 0xFFFF both give the 16-bit maximum of 65536 steps.
- R6: Within a period, `pwm_out` is high while the count is below the duty word and low after that. A duty of zero keeps the output low. A duty at or above the period length keeps it high.
- R7: A write to the duty or period word is applied at the next period boundary. A write that lands on the same edge as a boundary waits for the boundary after it.
- R8: Source field value 1 counts `tick_norm` strobes and value 2 counts `tick_fast` strobes. Values 0 and 3 select no source, so the counter stands still.
- R9: While `mode_dbg`, `mode_wait` or `mode_doze` is high and the matching run-in-mode bit is clear, the prescaler and counter freeze and the output holds its level. With the bit set, that mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Word write strobe |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_norm | input | 1 | Clock-enable strobe of the normal-rate source |
| tick_fast | input | 1 | Clock-enable strobe of the high-rate source |
| mode_dbg | input | 1 | Chip is in debug state |
| mode_wait | input | 1 | Chip is in wait state |
| mode_doze | input | 1 | Chip is in doze state |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 12-bit prescaler field and 5-bit offsets. With these widths, the full divide ratio of 4096 fits within the run budget. Periods of two to five steps let many boundaries pass in a few dozen cycles, so the scoreboard can place shadow-register writes on, just before and just after a boundary edge. Mode freezes and source selection are exercised mid-period on the same short periods.

// File: rtl/pwmgen_pkg.sv
`timescale 1ns/1ps
package pwmgen_pkg;

  // byte offsets of the three words
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_SAMPLE = 'h0C;
  localparam int OFS_PERIOD = 'h10;

  // control word layout
  localparam int EN_BIT   = 0;
  localparam int PSC_LSB  = 4;
  localparam int SRC_LSB  = 16;
  localparam int DBG_BIT  = 22;
  localparam int WAIT_BIT = 23;
  localparam int DOZE_BIT = 24;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NORM = 2'd1,
    SRC_FAST = 2'd2,
    SRC_RSVD = 2'd3
  } clk_src_e;

  // bits of the control word that hold state
  function automatic logic [31:0] ctrl_keep_mask(input int psc_w);
    logic [31:0] m;
    m = '0;
    m[EN_BIT] = 1'b1;
    for (int i = 0; i < psc_w; i++) m[PSC_LSB + i] = 1'b1;
    m[SRC_LSB]     = 1'b1;
    m[SRC_LSB + 1] = 1'b1;
    m[DBG_BIT]  = 1'b1;
    m[WAIT_BIT] = 1'b1;
    m[DOZE_BIT] = 1'b1;
    return m;
  endfunction

  // the strobe that advances the prescaler this cycle
  function automatic logic pick_tick(input clk_src_e src, input logic t_norm,
                                     input logic t_fast);
    case (src)
      SRC_NORM: return t_norm;
      SRC_FAST: return t_fast;
      default:  return 1'b0;
    endcase
  endfunction

  // counting is allowed unless a low-power mode is active without its permit
  function automatic logic run_allowed(input logic en,
                                       input logic m_dbg, input logic m_wait,
                                       input logic m_doze,
                                       input logic ok_dbg, input logic ok_wait,
                                       input logic ok_doze);
    return en && !(m_dbg && !ok_dbg) && !(m_wait && !ok_wait) && !(m_doze && !ok_doze);
  endfunction

endpackage

// File: rtl/pwmgen_regs.sv
`timescale 1ns/1ps
module pwmgen_regs
  import pwmgen_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ctl_en,
  output logic [PSC_W-1:0]  ctl_psc,
  output clk_src_e          ctl_src,
  output logic              ctl_dbg_ok,
  output logic              ctl_wait_ok,
  output logic              ctl_doze_ok,
  output logic [CNT_W-1:0]  sample_q,
  output logic [CNT_W-1:0]  period_q
);

  localparam logic [DATA_W-1:0] KEEP = DATA_W'(ctrl_keep_mask(PSC_W));

  logic [DATA_W-1:0] ctrl_q;

  // decoded hits, named for the checks below
  logic hit_ctrl, hit_sample, hit_period;
  assign hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_sample = (bus_addr == ADDR_W'(OFS_SAMPLE));
  assign hit_period = (bus_addr == ADDR_W'(OFS_PERIOD));

  logic wr_ctrl, wr_sample, wr_period;
  assign wr_ctrl   = bus_wr && hit_ctrl;
  assign wr_sample = bus_wr && hit_sample;
  assign wr_period = bus_wr && hit_period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sample_q <= '0;
      period_q <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= bus_wdata & KEEP;
      if (wr_sample) sample_q <= bus_wdata[CNT_W-1:0];
      if (wr_period) period_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)        bus_rdata = ctrl_q;
    else if (hit_sample) bus_rdata = DATA_W'(sample_q);
    else if (hit_period) bus_rdata = DATA_W'(period_q);
  end

  assign ctl_en      = ctrl_q[EN_BIT];
  assign ctl_psc     = ctrl_q[PSC_LSB +: PSC_W];
  assign ctl_src     = clk_src_e'(ctrl_q[SRC_LSB +: 2]);
  assign ctl_dbg_ok  = ctrl_q[DBG_BIT];
  assign ctl_wait_ok = ctrl_q[WAIT_BIT];
  assign ctl_doze_ok = ctrl_q[DOZE_BIT];

  // R2: a duty write is held exactly as written in its low field
  p_sample_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sample |=> sample_q == $past(bus_wdata[CNT_W-1:0]));

  // R2: a write to no mapped word leaves every word unchanged
  p_unmapped_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_ctrl && !hit_sample && !hit_period) |=>
      ($stable(ctrl_q) && $stable(sample_q) && $stable(period_q)));

endmodule

// File: rtl/pwmgen_prescale.sv
`timescale 1ns/1ps
module pwmgen_prescale
  import pwmgen_pkg::*;
#(
  parameter int PSC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  input  clk_src_e         src,
  input  logic             tick_norm,
  input  logic             tick_fast,
  input  logic             mode_dbg,
  input  logic             mode_wait,
  input  logic             mode_doze,
  input  logic             dbg_ok,
  input  logic             wait_ok,
  input  logic             doze_ok,
  output logic             run_ok,
  output logic             cnt_tick
);

  logic [PSC_W-1:0] pre_q;
  logic             src_tick;
  logic             wrap;

  assign src_tick = pick_tick(src, tick_norm, tick_fast);
  assign run_ok   = run_allowed(en, mode_dbg, mode_wait, mode_doze,
                                dbg_ok, wait_ok, doze_ok);
  // >= so that lowering the ratio mid-count wraps at once
  assign wrap     = (pre_q >= psc);
  assign cnt_tick = run_ok && src_tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (!en)              pre_q <= '0;
    else if (run_ok && src_tick) pre_q <= wrap ? '0 : pre_q + 1'b1;
  end

  // R9: a blocked mode freezes the divider
  p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !run_ok) |=> $stable(pre_q));

  // R4: a source tick that does not complete the ratio steps the divider by one
  p_psc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_ok && src_tick && !cnt_tick) |=> pre_q == $past(pre_q) + 1'b1);

  // R3: with the run bit clear the divider returns to zero
  p_psc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pre_q == '0);

endmodule

// File: rtl/pwmgen_core.sv
`timescale 1ns/1ps
module pwmgen_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] sample_reg,
  input  logic [CNT_W-1:0] period_reg,
  output logic             boundary,
  output logic             pwm_out
);

  // last count of a period: period word + 1, saturating at all ones
  function automatic logic [CNT_W-1:0] last_idx(input logic [CNT_W-1:0] per);
    return (per == '1) ? '1 : per + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_sample_q;
  logic [CNT_W-1:0] act_period_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = last_idx(act_period_q);
  assign boundary = cnt_tick && (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      act_sample_q <= '0;
      act_period_q <= '0;
    end else if (!en) begin
      cnt_q        <= '0;
      act_sample_q <= sample_reg;
      act_period_q <= period_reg;
    end else if (boundary) begin
      cnt_q        <= '0;
      act_sample_q <= sample_reg;
      act_period_q <= period_reg;
    end else if (cnt_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // compare of two flops; no extra register on the output
  assign pwm_out = en && (cnt_q < act_sample_q);

  // R5: the count never passes the last step of the active period
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt);

  // R5: a completed period restarts at zero
  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && boundary) |=> cnt_q == '0);

  // R3: disabled means the counter sits at zero
  p_idle_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == '0);

  // R7: the shadow values change only at a boundary while running
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !boundary) |=> ($stable(act_sample_q) && $stable(act_period_q)));

endmodule

// File: rtl/pwm_regmap_gen.sv
`timescale 1ns/1ps
module pwm_regmap_gen
  import pwmgen_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_norm,
  input  logic              tick_fast,
  input  logic              mode_dbg,
  input  logic              mode_wait,
  input  logic              mode_doze,
  output logic              pwm_out
);

  logic             ctl_en;
  logic [PSC_W-1:0] ctl_psc;
  clk_src_e         ctl_src;
  logic             ctl_dbg_ok, ctl_wait_ok, ctl_doze_ok;
  logic [CNT_W-1:0] sample_q, period_q;
  logic             run_ok, cnt_tick, boundary;

  pwmgen_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ctl_en     (ctl_en),
    .ctl_psc    (ctl_psc),
    .ctl_src    (ctl_src),
    .ctl_dbg_ok (ctl_dbg_ok),
    .ctl_wait_ok(ctl_wait_ok),
    .ctl_doze_ok(ctl_doze_ok),
    .sample_q   (sample_q),
    .period_q   (period_q)
  );

  pwmgen_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl_en),
    .psc      (ctl_psc),
    .src      (ctl_src),
    .tick_norm(tick_norm),
    .tick_fast(tick_fast),
    .mode_dbg (mode_dbg),
    .mode_wait(mode_wait),
    .mode_doze(mode_doze),
    .dbg_ok   (ctl_dbg_ok),
    .wait_ok  (ctl_wait_ok),
    .doze_ok  (ctl_doze_ok),
    .run_ok   (run_ok),
    .cnt_tick (cnt_tick)
  );

  pwmgen_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctl_en),
    .cnt_tick  (cnt_tick),
    .sample_reg(sample_q),
    .period_reg(period_q),
    .boundary  (boundary),
    .pwm_out   (pwm_out)
  );

  // R8: the counter only steps on a cycle where counting is permitted
  p_tick_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick |-> run_ok);

  // R9: a boundary cannot occur while a blocked mode is active
  p_no_wrap_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |-> !boundary);

endmodule

// File: tb/pwm_regmap_gen_bench.sv
`timescale 1ns/1ps
module pwm_regmap_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_norm = 1'b1;
  logic        tick_fast = 1'b0;
  logic        mode_dbg = 1'b0;
  logic        mode_wait = 1'b0;
  logic        mode_doze = 1'b0;
  logic        pwm_out;

  always #2.5 clk = ~clk;

  pwm_regmap_gen u_pwm_regmap_gen (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_norm(tick_norm),
    .tick_fast(tick_fast), .mode_dbg(mode_dbg), .mode_wait(mode_wait),
    .mode_doze(mode_doze), .pwm_out(pwm_out)
  );

  localparam logic [4:0] A_CTRL = 5'h00, A_DUTY = 5'h0C, A_PER = 5'h10;
  localparam int NEVER = 1 << 30;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct { int req; int idx; logic val; } sb_item_t;
  sb_item_t sb_q[$];

  // expected-waveform model, written from the requirements
  int g_ratio = 1, g_eff_a = 2, g_samp_a = 0;
  int g_k0 = NEVER, g_eff_b = 2, g_samp_b = 0;
  int g_fz = NEVER, g_fzlen = 0;
  logic [31:0] g_ctrl = '0;

  function automatic int eff_of(input int per);
    return (per >= 65534) ? 65536 : per + 2;
  endfunction

  function automatic logic exp_at(input int k);
    int held, t, c;
    held = k - g_fz;
    if (held < 0) held = 0;
    if (held > g_fzlen) held = g_fzlen;
    t = k - held;
    if (k < g_k0) begin
      c = (t / g_ratio) % g_eff_a;
      return c < g_samp_a;
    end
    c = (k - g_k0) % g_eff_b;
    return c < g_samp_b;
  endfunction

  function automatic logic [31:0] mk_ctrl(input int psc, input int src,
                                          input bit dbg, input bit wt, input bit dz);
    return {7'b0, dz, wt, dbg, 4'b0, 2'(src), 12'(psc), 3'b0, 1'b1};
  endfunction

  task automatic note(input int req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h want %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_check(input int req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    note(req, $sformatf("read of offset %h", a), bus_rdata, exp);
  endtask

  // disable, load words, reset the model
  task automatic prep(input int psc, input int src, input int per, input int samp,
                      input bit dbg, input bit wt, input bit dz);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_PER, 32'(per));
    bus_write(A_DUTY, 32'(samp));
    g_ctrl = mk_ctrl(psc, src, dbg, wt, dz);
    g_ratio = psc + 1; g_eff_a = eff_of(per); g_samp_a = samp;
    g_k0 = NEVER; g_fz = NEVER; g_fzlen = 0;
  endtask

  // enable and hand the expected waveform to the monitor; returns at cycle 0
  task automatic go(input int req, input int n);
    bus_write(A_CTRL, g_ctrl);
    for (int k = 0; k < n; k++) begin
      sb_item_t it;
      it.req = req; it.idx = k; it.val = exp_at(k);
      sb_q.push_back(it);
    end
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
  endtask

  // monitor: compares one expected item per cycle, away from the edge
  initial forever begin
    sb_item_t it;
    @(negedge clk);
    #1;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      note(it.req, $sformatf("pwm_out at cycle %0d", it.idx),
           {31'b0, pwm_out}, {31'b0, it.val});
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #1; note(1, "pwm_out after reset", {31'b0, pwm_out}, 32'h0);
    bus_check(1, A_CTRL, 32'h0);
    bus_check(1, A_DUTY, 32'h0);
    bus_check(1, A_PER, 32'h0);

    // R2: reserved control bits read zero, fields read back
    bus_write(A_CTRL, 32'hFFFF_FFFF);
    bus_check(2, A_CTRL, 32'h01C3_FFF1);
    bus_write(A_CTRL, 32'h0);
    // R2: unmapped offset reads zero and its write is dropped
    bus_write(5'h04, 32'h0000_ABCD);
    bus_check(2, 5'h04, 32'h0);
    bus_check(2, A_CTRL, 32'h0);
    bus_write(A_DUTY, 32'hFFFF_1234);
    bus_check(2, A_DUTY, 32'h0000_1234);
    bus_write(A_PER, 32'hDEAD_0007);
    bus_check(2, A_PER, 32'h0000_0007);
    bus_write(5'h14, 32'hFFFF_FFFF);
    bus_check(2, A_PER, 32'h0000_0007);
    bus_check(2, A_DUTY, 32'h0000_1234);

    // R6 / R5: period word 3 gives five steps, duty 2
    prep(0, 1, 3, 2, 0, 0, 0);
    go(6, 20); drain();

    // R3: stop mid-period, output low; restart begins at count zero
    prep(0, 1, 3, 2, 0, 0, 0);
    go(3, 7); drain();
    bus_write(A_CTRL, 32'h0);
    #1; note(3, "pwm_out after run bit cleared", {31'b0, pwm_out}, 32'h0);
    repeat (3) @(negedge clk);
    #1; note(3, "pwm_out stays low while stopped", {31'b0, pwm_out}, 32'h0);
    go(3, 10); drain();

    // R4: field 2 divides by three, period word 1 gives three steps
    prep(2, 1, 1, 1, 0, 0, 0);
    go(4, 30); drain();

    // R6: duty zero low, duty above and equal to the length high
    prep(0, 1, 3, 0, 0, 0, 0);
    go(6, 12); drain();
    prep(0, 1, 3, 9, 0, 0, 0);
    go(6, 12); drain();
    prep(0, 1, 3, 5, 0, 0, 0);
    go(6, 12); drain();

    // R7: duty write at cycle 8 applies from the boundary at cycle 10
    prep(0, 1, 3, 2, 0, 0, 0);
    g_k0 = 10; g_eff_b = 5; g_samp_b = 4;
    go(7, 25);
    repeat (8) @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_DUTY; bus_wdata = 32'd4;
    @(negedge clk); bus_wr = 1'b0;
    drain();

    // R7: duty write on the boundary edge waits one more period (cycle 15)
    prep(0, 1, 3, 2, 0, 0, 0);
    g_k0 = 15; g_eff_b = 5; g_samp_b = 4;
    go(7, 25);
    repeat (9) @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_DUTY; bus_wdata = 32'd4;
    @(negedge clk); bus_wr = 1'b0;
    drain();

    // R7: period write at cycle 2 applies from cycle 5
    prep(0, 1, 3, 2, 0, 0, 0);
    g_k0 = 5; g_eff_b = 3; g_samp_b = 2;
    go(7, 20);
    repeat (2) @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_PER; bus_wdata = 32'd1;
    @(negedge clk); bus_wr = 1'b0;
    drain();

    // R8: source 2 counts the fast strobe
    tick_norm = 1'b0; tick_fast = 1'b1;
    prep(0, 2, 3, 2, 0, 0, 0);
    go(8, 15); drain();
    // R8: source 1 with only the fast strobe active never advances
    prep(0, 1, 3, 1, 0, 0, 0);
    g_fz = 0; g_fzlen = NEVER;
    go(8, 12); drain();
    // R8: source 0 never advances
    prep(0, 0, 3, 1, 0, 0, 0);
    g_fz = 0; g_fzlen = NEVER;
    go(8, 12); drain();
    tick_norm = 1'b1; tick_fast = 1'b0;

    // R9: wait mode without permit freezes cycles 3..6
    prep(0, 1, 3, 2, 0, 0, 0);
    g_fz = 3; g_fzlen = 4;
    go(9, 20);
    repeat (3) @(negedge clk); mode_wait = 1'b1;
    repeat (4) @(negedge clk); mode_wait = 1'b0;
    drain();

    // R9: debug mode with permit set changes nothing
    mode_dbg = 1'b1;
    prep(0, 1, 3, 2, 1, 0, 0);
    go(9, 15); drain();
    mode_dbg = 1'b0;

    // R9: doze mode without permit holds the first step
    mode_doze = 1'b1;
    prep(0, 1, 3, 1, 0, 0, 0);
    g_fz = 0; g_fzlen = NEVER;
    go(9, 12); drain();
    mode_doze = 1'b0;

    // R4 / R5: largest ratio with the shortest period
    prep(4095, 1, 0, 1, 0, 0, 0);
    go(4, 10000); drain();

    bus_write(A_CTRL, 32'h0);
    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule